// File: doc/BRIEF.md
# Buffered Input Capture Bank

This block holds eight input-capture channels. Each one samples a free-running 16-bit timer value when a chosen edge appears on its input pin. The pins are brought into the clock domain by a two-flop synchronizer, and edges are found on the synchronized copy. Channels 0 to 3 are buffered. They keep a capture register and a holding register, so two timer stamps can build up before software looks at them. Channels 4 to 7 keep a single capture register.

Each channel has a no-overwrite control. When it is set, a register takes a new value only while it is empty. An event that would overwrite a stored value is dropped. Per-channel flags are cleared by writing 1 and are combined with per-channel enables into one interrupt line. On a buffered channel the flag is raised only once both of its registers hold data, which lets software measure a pulse or period from a single interrupt.

Software reaches all state through a flat register port with a combinational read and single-cycle write and read strobes. Reading a capture or holding register marks it empty.

Top module: `capture_bank`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: Address 0 holds the edge modes, with bits [2n+1:2n] for channel n: 00 off, 01 rising, 10 falling, 11 both. A pin change set up before a clock edge is captured at the third clock edge, counting that edge as the first. The value stored is the `tmr_i` present at that third edge. A channel in mode 00 never captures.
- R3: Address 1 holds the no-overwrite bits, with bit n for channel n. Address 2 holds the interrupt-enable bits, with bit n for channel n. Both are write/read registers.
- R4: The capture register of channel n is at address 8+n. On channels 4 to 7, an accepted event stores the timer value, marks the register full and sets flag n. These channels have no holding register, and address 16+n reads 0.
- R5: The holding register of buffered channel n is at address 16+n. When an event arrives while the capture register is full and the transfer is allowed, two things happen in the same cycle:
  - the old capture value moves to the holding register;
  - the new timer value enters the capture register.
- R6: With the no-overwrite bit at 1, an event is dropped if it would write a full register. This covers a full capture register on channels 4 to 7, and a full capture register together with a full holding register on channels 0 to 3. A dropped event leaves both registers and the flag unchanged.
- R7: A buffered channel sets its flag only when an accepted event leaves both its capture and holding registers full.
- R8: Address 3 holds the flags, with bit n for channel n. Writing 1 to a bit clears it. A set in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when some flag bit and its enable bit are both 1.
- R10: A read strobe on a capture or holding register address marks that register empty. An event in the same cycle takes priority and leaves it full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Channel input pins, asynchronous |
| tmr_i | input | 16 | Free-running timer count |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (read side effects) |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that the bus strobes, the address and the write data are known values after reset and hold steady through each clock edge. They also assume that an event happens only when the synchronizer produces one. Nothing is assumed about `tmr_i`, which may take any value on any cycle.

The bench changes every input on the falling clock edge. It issues at most one bus access per cycle. It moves the timer by an odd step, so that consecutive stamps differ and a misplaced capture shows up in the read data. The random phase mixes reads and writes with pin toggles, so that reads, events and flag clears meet in the same cycle.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    localparam int unsigned CTRL_REGS = 4;
endpackage

// File: rtl/cap_edge_det.sv
`timescale 1ns/1ps
module cap_edge_det #(
    parameter int unsigned NCH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           pin_i,
    input  logic [NCH-1:0][1:0]      mode_i,
    output logic [NCH-1:0]           ev_o
);
    import cap_pkg::*;

    typedef struct packed {
        logic [NCH-1:0] meta;
        logic [NCH-1:0] sync;
        logic [NCH-1:0] prev;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.meta = pin_i;
        det_d.sync = det_q.meta;
        det_d.prev = det_q.sync;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ev
        logic       rise_w, fall_w;
        edge_mode_e mode_w;
        assign mode_w = edge_mode_e'(mode_i[g]);
        assign rise_w = det_q.sync[g] & ~det_q.prev[g];
        assign fall_w = ~det_q.sync[g] & det_q.prev[g];
        always_comb begin
            unique case (mode_w)
                EDGE_RISE: ev_o[g] = rise_w;
                EDGE_FALL: ev_o[g] = fall_w;
                EDGE_ANY:  ev_o[g] = rise_w | fall_w;
                default:   ev_o[g] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end
endmodule

// File: rtl/cap_chan.sv
`timescale 1ns/1ps
module cap_chan #(
    parameter int unsigned TW       = 16,
    parameter bit          BUFFERED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_i,
    input  logic          novw_i,
    input  logic [TW-1:0] tmr_i,
    input  logic          rd_cap_i,
    input  logic          rd_hold_i,
    output logic [TW-1:0] cap_o,
    output logic [TW-1:0] hold_o,
    output logic          cap_full_o,
    output logic          hold_full_o,
    output logic          set_o
);
    typedef struct packed {
        logic [TW-1:0] cap;
        logic [TW-1:0] hold;
        logic          cap_full;
        logic          hold_full;
    } chan_t;

    chan_t st_d, st_q;
    logic  set_d;

    always_comb begin
        st_d  = st_q;
        set_d = 1'b0;
        if (rd_cap_i)  st_d.cap_full  = 1'b0;
        if (rd_hold_i) st_d.hold_full = 1'b0;
        if (ev_i) begin
            if (BUFFERED) begin
                if (st_q.cap_full) begin
                    if (!novw_i || !st_q.hold_full) begin
                        st_d.hold      = st_q.cap;
                        st_d.hold_full = 1'b1;
                        st_d.cap       = tmr_i;
                        st_d.cap_full  = 1'b1;
                        set_d          = 1'b1;
                    end
                end else begin
                    st_d.cap      = tmr_i;
                    st_d.cap_full = 1'b1;
                    set_d         = st_d.hold_full;
                end
            end else if (!novw_i || !st_q.cap_full) begin
                st_d.cap      = tmr_i;
                st_d.cap_full = 1'b1;
                set_d         = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o       = st_q.cap;
    assign hold_o      = st_q.hold;
    assign cap_full_o  = st_q.cap_full;
    assign hold_full_o = st_q.hold_full;
    assign set_o       = set_d;
endmodule

// File: rtl/capture_bank.sv
`timescale 1ns/1ps
module capture_bank #(
    parameter int unsigned NCH  = 8,
    parameter int unsigned NBUF = 4,
    parameter int unsigned TW   = 16,
    parameter int unsigned AW   = 5,
    parameter int unsigned DW   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    pin_i,
    input  logic [15:0]   tmr_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [4:0]    addr_i,
    input  logic [15:0]   wdata_i,
    output logic [15:0]   rdata_o,
    output logic          irq_o
);
    import cap_pkg::*;

    localparam int unsigned ESW       = 2 * NCH;
    localparam int unsigned SPAN      = 2 ** $clog2(NCH);
    localparam int unsigned A_EDGE    = 0;
    localparam int unsigned A_NOVW    = 1;
    localparam int unsigned A_IEN     = 2;
    localparam int unsigned A_FLAG    = CTRL_REGS - 1;
    localparam int unsigned CAP_BASE  = SPAN;
    localparam int unsigned HOLD_BASE = 2 * SPAN;

    typedef struct packed {
        logic [NCH-1:0][1:0] esel;
        logic [NCH-1:0]      novw;
        logic [NCH-1:0]      ien;
        logic [NCH-1:0]      flag;
    } bank_t;

    bank_t st_d, st_q;

    logic [NCH-1:0]         ev;
    logic [NCH-1:0]         set_all;
    logic [NCH-1:0]         rd_cap, rd_hold;
    logic [NCH-1:0][TW-1:0] cap_all, hold_all;
    logic [NCH-1:0]         cap_full_all, hold_full_all;
    logic [NCH-1:0]         novw_w, flag_w;

    cap_edge_det #(.NCH(NCH)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .mode_i (st_q.esel),
        .ev_o   (ev)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign rd_cap[g]  = rd_en_i && (addr_i == AW'(CAP_BASE + g));
        assign rd_hold[g] = rd_en_i && (addr_i == AW'(HOLD_BASE + g));
        cap_chan #(.TW(TW), .BUFFERED(g < NBUF)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .ev_i        (ev[g]),
            .novw_i      (st_q.novw[g]),
            .tmr_i       (tmr_i),
            .rd_cap_i    (rd_cap[g]),
            .rd_hold_i   (rd_hold[g]),
            .cap_o       (cap_all[g]),
            .hold_o      (hold_all[g]),
            .cap_full_o  (cap_full_all[g]),
            .hold_full_o (hold_full_all[g]),
            .set_o       (set_all[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            unique case (addr_i)
                AW'(A_EDGE): st_d.esel = wdata_i[ESW-1:0];
                AW'(A_NOVW): st_d.novw = wdata_i[NCH-1:0];
                AW'(A_IEN):  st_d.ien  = wdata_i[NCH-1:0];
                default: ;
            endcase
        end
        if (wr_en_i && addr_i == AW'(A_FLAG))
            st_d.flag = st_q.flag & ~wdata_i[NCH-1:0];
        st_d.flag = st_d.flag | set_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(A_EDGE)) rdata_o = DW'(st_q.esel);
        if (addr_i == AW'(A_NOVW)) rdata_o = DW'(st_q.novw);
        if (addr_i == AW'(A_IEN))  rdata_o = DW'(st_q.ien);
        if (addr_i == AW'(A_FLAG)) rdata_o = DW'(st_q.flag);
        for (int g = 0; g < NCH; g++) begin
            if (addr_i == AW'(CAP_BASE + g))  rdata_o = DW'(cap_all[g]);
            if (addr_i == AW'(HOLD_BASE + g)) rdata_o = DW'(hold_all[g]);
        end
    end

    assign irq_o  = |(st_q.flag & st_q.ien);
    assign novw_w = st_q.novw;
    assign flag_w = st_q.flag;
endmodule

// File: rtl/cap_bank_chk.sv
`timescale 1ns/1ps
module cap_bank_chk #(
    parameter int unsigned NCH    = 8,
    parameter int unsigned NBUF   = 4,
    parameter int unsigned TW     = 16,
    parameter int unsigned AW     = 5,
    parameter int unsigned DW     = 16,
    parameter int unsigned A_FLAG = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         ev,
    input logic [NCH-1:0]         novw,
    input logic [NCH-1:0]         cap_full,
    input logic [NCH-1:0]         hold_full,
    input logic [NCH-1:0][TW-1:0] cap_v,
    input logic [NCH-1:0][TW-1:0] hold_v,
    input logic [NCH-1:0]         flag,
    input logic [TW-1:0]          tmr,
    input logic                   wr_en,
    input logic [AW-1:0]          addr,
    input logic [DW-1:0]          wdata
);
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_CAPTURE_TAKES_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
            ev[g] && (!novw[g] || !cap_full[g]) |=> cap_v[g] == $past(tmr) && cap_full[g]); // R4
        AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && addr == AW'(A_FLAG) && wdata[g] && !ev[g] |=> !flag[g]); // R8
        if (g < NBUF) begin : g_buf
            AST_TRANSFER_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                ev[g] && cap_full[g] && (!novw[g] || !hold_full[g])
                |=> hold_v[g] == $past(cap_v[g]) && hold_full[g]); // R5
            AST_BLOCKED_KEEPS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
                ev[g] && novw[g] && cap_full[g] && hold_full[g]
                |=> $stable(cap_v[g]) && $stable(hold_v[g])); // R6
            AST_FLAG_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag[g]) |-> cap_full[g] && hold_full[g]); // R7
        end else begin : g_single
            AST_BLOCKED_KEEPS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                ev[g] && novw[g] && cap_full[g] |=> $stable(cap_v[g])); // R6
            AST_NO_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
                !hold_full[g] && hold_v[g] == '0); // R4
        end
    end
endmodule

bind capture_bank cap_bank_chk #(
    .NCH(NCH), .NBUF(NBUF), .TW(TW), .AW(AW), .DW(DW), .A_FLAG(A_FLAG)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .novw      (novw_w),
    .cap_full  (cap_full_all),
    .hold_full (hold_full_all),
    .cap_v     (cap_all),
    .hold_v    (hold_all),
    .flag      (flag_w),
    .tmr       (tmr_i),
    .wr_en     (wr_en_i),
    .addr      (addr_i),
    .wdata     (wdata_i)
);

// File: tb/capture_bank_tb_top.sv
`timescale 1ns/1ps
module capture_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin = '0;
    logic [15:0] tmr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int nchecks = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    capture_bank dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .tmr_i(tmr),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // reference model state
    int unsigned mc[8], mh[8];
    bit mcf[8], mhf[8];
    bit s1[8], s2[8], pv[8];
    bit [15:0] es;
    bit [7:0]  nv, ie, fl;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                mc[i] = 0; mh[i] = 0; mcf[i] = 0; mhf[i] = 0;
                s1[i] = 0; s2[i] = 0; pv[i] = 0;
            end
            es = '0; nv = '0; ie = '0; fl = '0;
        end else begin
            bit [7:0] setm;
            setm = '0;
            for (int i = 0; i < 8; i++) begin
                bit ev, ocf, ohf;
                bit [1:0] md;
                md = es[2*i +: 2];
                ev = (md[0] && s2[i] && !pv[i]) || (md[1] && !s2[i] && pv[i]);
                pv[i] = s2[i]; s2[i] = s1[i]; s1[i] = pin[i];
                ocf = mcf[i]; ohf = mhf[i];
                if (rd_en && addr == 5'(8 + i)) mcf[i] = 0;
                if (rd_en && addr == 5'(16 + i) && i < 4) mhf[i] = 0;
                if (ev) begin
                    if (i < 4) begin
                        if (ocf) begin
                            if (!nv[i] || !ohf) begin
                                mh[i] = mc[i]; mhf[i] = 1; mc[i] = tmr; mcf[i] = 1; setm[i] = 1;
                            end
                        end else begin
                            mc[i] = tmr; mcf[i] = 1; setm[i] = mhf[i];
                        end
                    end else if (!nv[i] || !ocf) begin
                        mc[i] = tmr; mcf[i] = 1; setm[i] = 1;
                    end
                end
            end
            if (wr_en) begin
                case (addr)
                    5'd0: es = wdata;
                    5'd1: nv = wdata[7:0];
                    5'd2: ie = wdata[7:0];
                    5'd3: fl = fl & ~wdata[7:0];
                    default: ;
                endcase
            end
            fl = fl | setm;
        end
    end

    function automatic logic [15:0] mread(logic [4:0] a);
        if (a == 0) return es;
        if (a == 1) return {8'h0, nv};
        if (a == 2) return {8'h0, ie};
        if (a == 3) return {8'h0, fl};
        if (a >= 8 && a < 16) return 16'(mc[a-8]);
        if (a >= 16 && a < 20) return 16'(mh[a-16]);
        return 16'h0;
    endfunction

    function automatic string tag_of(logic [4:0] a);
        if (a < 3) return "R3";
        if (a == 3) return "R8";
        if (a >= 8 && a < 12) return "R5";
        if (a >= 12 && a < 16) return "R4";
        if (a >= 16 && a < 20) return "R5";
        return "R4";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s addr=%0d actual=%0h expected=%0h", tag, addr, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(tag_of(addr), rdata, mread(addr));
        chk("R9", irq, |(fl & ie));
        tmr = tmr + 16'd37;
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic bus_wr(logic [4:0] a, logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [4:0] a);
        rd_en = 1'b1; addr = a;
        step();
        rd_en = 1'b0;
    endtask

    task automatic peek(logic [4:0] a, logic [15:0] exp, string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    initial begin
        logic [15:0] c0, h0;
        steps(3);
        rst_n = 1'b1;
        step();
        // R1: reset values
        peek(5'd0, 16'h0, "R1");
        peek(5'd3, 16'h0, "R1");
        peek(5'd8, 16'h0, "R1");
        peek(5'd16, 16'h0, "R1");
        chk("R1", irq, 1'b0);

        // R2: per-channel edge modes
        bus_wr(5'd0, 16'hED39);
        bus_wr(5'd2, 16'h00FF);
        peek(5'd2, 16'h00FF, "R3");
        pin = 8'h11; steps(4);
        peek(5'd3, 16'h0010, "R7");   // ch0 one value only, ch4 flagged (R4)
        pin = 8'h00; steps(4);
        pin = 8'h11; steps(4);
        peek(5'd3, 16'h0011, "R7");
        chk("R9", irq, 1'b1);
        bus_wr(5'd3, 16'h0011);
        peek(5'd3, 16'h0000, "R8");
        chk("R9", irq, 1'b0);
        pin = 8'h08; steps(4); pin = 8'h00; steps(4);
        peek(5'd11, 16'h0000, "R2"); // ch3 mode off
        peek(5'd19, 16'h0000, "R2");

        // R6: blocked event on a full pair
        bus_wr(5'd1, 16'h00FF);
        peek(5'd1, 16'h00FF, "R3");
        peek(5'd8, mread(5'd8), "R5"); c0 = rdata;
        peek(5'd16, mread(5'd16), "R5"); h0 = rdata;
        pin = 8'h01; steps(4); pin = 8'h00; steps(4);
        peek(5'd8, c0, "R6");
        peek(5'd16, h0, "R6");
        peek(5'd3, 16'h0000, "R6");

        // R10: reading capture frees it; next edge flags since hold still full
        bus_rd(5'd8);
        pin = 8'h01; steps(4);
        peek(5'd16, h0, "R10");
        peek(5'd3, 16'h0001, "R10");
        chk("R7", rdata[0], 1'b1);

        // R4 unbuffered hold address reads zero
        peek(5'd20, 16'h0000, "R4");

        // random mixed phase
        for (int k = 0; k < 6000; k++) begin
            int r;
            r = $urandom_range(0, 19);
            if ($urandom_range(0, 3) == 0) pin = 8'($urandom);
            if (r < 6) begin
                rd_en = 1'b1; addr = 5'($urandom_range(8, 19));
            end else if (r == 6) begin
                wr_en = 1'b1; addr = 5'd3; wdata = 16'($urandom);
            end else if (r == 7 && $urandom_range(0, 9) == 0) begin
                wr_en = 1'b1; addr = 5'd1; wdata = 16'($urandom);
            end else if (r == 8 && $urandom_range(0, 19) == 0) begin
                wr_en = 1'b1; addr = 5'd0; wdata = 16'($urandom);
            end else begin
                addr = 5'($urandom_range(0, 20));
            end
            step();
            rd_en = 1'b0; wr_en = 1'b0;
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            nchecks++; nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end
endmodule